// File: doc/BRIEF.md
# DMA Byte-Lane Steering Unit

This unit connects a 16-bit multiplexed address/data bus to an 8-bit DMA data path inside a peripheral. A host-written configuration byte carries a swap-enable flag and an endianness-polarity flag. When a DMA transfer moves data from memory into the peripheral, the unit chooses one of the two bus byte lanes. The choice depends on those two flags and on the least significant bit of the DMA address. The chosen byte is captured in a register, and a one-cycle valid pulse accompanies it.

When the peripheral sends a byte toward memory, the unit places that same byte on both halves of the bus. The memory strobes outside the block then decide which half actually gets written. The unit enables the lane drivers only while a DMA write strobe is active. Request/acknowledge sequencing, strobe generation and address counting happen elsewhere.

Top module: `dma_lane_steer`

## Requirements
- R1: After reset, the configuration readback is 0x00, `rx_valid` is 0 and `rx_byte` is 0x00. Swapping is therefore disabled.
- R2: A host write with `cfg_wr_en` high stores bit 7 (swap enable), bit 6 (swap polarity) and bits 2:0. Readback always returns bits 5:3 as zero, whatever value was written to them.
- R3: When swap enable (config bit 7) is 0, the captured byte is always `bus_in[7:0]`, for either value of `dma_addr0`. `bus_in[15:8]` has no effect.
- R4: When swap enable is 1 and polarity (config bit 6) is 1, a transfer with `dma_addr0`=0 captures `bus_in[7:0]` and a transfer with `dma_addr0`=1 captures `bus_in[15:8]`.
- R5: When swap enable is 1 and polarity is 0, a transfer with `dma_addr0`=0 captures `bus_in[15:8]` and a transfer with `dma_addr0`=1 captures `bus_in[7:0]`.
- R6: `rx_byte` is loaded on each rising clock edge where `dma_rd_stb` is high. `rx_valid` is high for exactly the cycle after each such edge. Without a strobe, `rx_byte` holds its value.
- R7: `bus_out[15:8]` and `bus_out[7:0]` both equal `tx_byte` for every configuration value.
- R8: `bus_oe_lo` and `bus_oe_hi` are high only while `dma_wr_stb` is high, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Host write strobe for the configuration byte |
| cfg_wr_data | input | 8 | Host write data |
| cfg_rd_data | output | 8 | Configuration readback, bits 5:3 forced to zero |
| dma_addr0 | input | 1 | Least significant bit of the current DMA address |
| bus_in | input | 16 | Incoming bus data, both lanes |
| dma_rd_stb | input | 1 | Memory-to-peripheral transfer strobe |
| rx_byte | output | 8 | Captured incoming byte |
| rx_valid | output | 1 | One-cycle pulse after a capture |
| tx_byte | input | 8 | Outgoing byte from the peripheral |
| dma_wr_stb | input | 1 | Peripheral-to-memory transfer strobe |
| bus_out | output | 16 | Outgoing bus data, byte mirrored on both lanes |
| bus_oe_lo | output | 1 | Driver enable for bus bits 7:0 |
| bus_oe_hi | output | 1 | Driver enable for bus bits 15:8 |

## Verification
Every configuration byte value is written and read back. This separates stored fields from the reserved ones. Incoming transfers are swept over all four enable/polarity combinations and both address parities. They use bus words whose two halves differ (distinct constants, complements, and a walking pattern), so selecting the wrong lane always produces a detectable byte. Idle cycles with changed bus data show that the capture register holds and that the valid pulse lasts one cycle. All 256 outgoing bytes are driven under different configurations, with the write strobe both on and off. This confirms that the lanes are mirrored and that the driver enables follow only the strobe.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;

    localparam int CFG_W      = 8;
    localparam int CFG_EN_BIT = 7;
    localparam int CFG_POL_BIT = 6;
    localparam int AUX_W      = 3;

    typedef struct packed {
        logic             swap_en;
        logic             swap_pol;
        logic [AUX_W-1:0] aux;
    } steer_cfg_t;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_t;

endpackage

// File: rtl/steer_cfg_reg.sv
module steer_cfg_reg
    import lane_steer_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output steer_cfg_t       cfg,
    output logic [CFG_W-1:0] rd_data
);

    steer_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d.swap_en  = wr_data[CFG_EN_BIT];
            cfg_d.swap_pol = wr_data[CFG_POL_BIT];
            cfg_d.aux      = wr_data[AUX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        rd_data                = '0;
        rd_data[CFG_EN_BIT]    = cfg_q.swap_en;
        rd_data[CFG_POL_BIT]   = cfg_q.swap_pol;
        rd_data[AUX_W-1:0]     = cfg_q.aux;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/steer_lane_pick.sv
module steer_lane_pick
    import lane_steer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              swap_en,
    input  logic              swap_pol,
    input  logic              addr0,
    input  logic [2*BYTE_W-1:0] bus_in,
    output logic [BYTE_W-1:0] byte_out
);

    lane_t lane;

    // High lane when swapping and the address parity matches the polarity bit
    always_comb begin
        lane = LANE_LO;
        if (swap_en && (addr0 == swap_pol)) lane = LANE_HI;
    end

    always_comb begin
        byte_out = (lane == LANE_HI) ? bus_in[2*BYTE_W-1:BYTE_W]
                                     : bus_in[BYTE_W-1:0];
    end

endmodule

// File: rtl/steer_rx_capture.sv
module steer_rx_capture #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stb,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [BYTE_W-1:0] byte_out,
    output logic              valid
);

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              vld;
    } rx_state_t;

    rx_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = stb;
        if (stb) st_d.data = byte_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign byte_out = st_q.data;
    assign valid    = st_q.vld;

endmodule

// File: rtl/steer_tx_mirror.sv
module steer_tx_mirror #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                     stb,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic [LANES*BYTE_W-1:0]  bus_out,
    output logic [LANES-1:0]         lane_oe
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign bus_out[g*BYTE_W +: BYTE_W] = byte_in;
        assign lane_oe[g]                  = stb;
    end

endmodule

// File: rtl/dma_lane_steer.sv
module dma_lane_steer
    import lane_steer_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_wr_en,
    input  logic [CFG_W-1:0]    cfg_wr_data,
    output logic [CFG_W-1:0]    cfg_rd_data,
    input  logic                dma_addr0,
    input  logic [2*BYTE_W-1:0] bus_in,
    input  logic                dma_rd_stb,
    output logic [BYTE_W-1:0]   rx_byte,
    output logic                rx_valid,
    input  logic [BYTE_W-1:0]   tx_byte,
    input  logic                dma_wr_stb,
    output logic [2*BYTE_W-1:0] bus_out,
    output logic                bus_oe_lo,
    output logic                bus_oe_hi
);

    localparam int LANES = 2;

    steer_cfg_t        cfg;
    logic [BYTE_W-1:0] picked;
    logic [LANES-1:0]  lane_oe;

    steer_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg     (cfg),
        .rd_data (cfg_rd_data)
    );

    steer_lane_pick #(.BYTE_W(BYTE_W)) u_pick (
        .swap_en  (cfg.swap_en),
        .swap_pol (cfg.swap_pol),
        .addr0    (dma_addr0),
        .bus_in   (bus_in),
        .byte_out (picked)
    );

    steer_rx_capture #(.BYTE_W(BYTE_W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .stb      (dma_rd_stb),
        .byte_in  (picked),
        .byte_out (rx_byte),
        .valid    (rx_valid)
    );

    steer_tx_mirror #(.BYTE_W(BYTE_W), .LANES(LANES)) u_tx (
        .stb     (dma_wr_stb),
        .byte_in (tx_byte),
        .bus_out (bus_out),
        .lane_oe (lane_oe)
    );

    assign bus_oe_lo = lane_oe[0];
    assign bus_oe_hi = lane_oe[1];

endmodule

// File: rtl/dma_lane_steer_chk.sv
module dma_lane_steer_chk #(
    parameter int BYTE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic [7:0]          cfg_rd_data,
    input logic                dma_addr0,
    input logic [2*BYTE_W-1:0] bus_in,
    input logic                dma_rd_stb,
    input logic [BYTE_W-1:0]   rx_byte,
    input logic                rx_valid,
    input logic [BYTE_W-1:0]   tx_byte,
    input logic                dma_wr_stb,
    input logic [2*BYTE_W-1:0] bus_out,
    input logic                bus_oe_lo,
    input logic                bus_oe_hi
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rd_data[5:3] == 3'b000); // R2

    AST_NOSWAP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_stb && !cfg_rd_data[7]) |=> rx_byte == $past(bus_in[BYTE_W-1:0])); // R3

    AST_POL1_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_stb && cfg_rd_data[7] && cfg_rd_data[6]) |=>
        rx_byte == ($past(dma_addr0) ? $past(bus_in[2*BYTE_W-1:BYTE_W])
                                     : $past(bus_in[BYTE_W-1:0]))); // R4

    AST_POL0_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd_stb && cfg_rd_data[7] && !cfg_rd_data[6]) |=>
        rx_byte == ($past(dma_addr0) ? $past(bus_in[BYTE_W-1:0])
                                     : $past(bus_in[2*BYTE_W-1:BYTE_W]))); // R5

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd_stb |=> rx_valid); // R6

    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !dma_rd_stb |=> (!rx_valid && $stable(rx_byte))); // R6

    AST_TX_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_out[2*BYTE_W-1:BYTE_W] == tx_byte) && (bus_out[BYTE_W-1:0] == tx_byte)); // R7

    AST_OE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe_lo || bus_oe_hi) |-> dma_wr_stb); // R8

endmodule

bind dma_lane_steer dma_lane_steer_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_rd_data (cfg_rd_data),
    .dma_addr0   (dma_addr0),
    .bus_in      (bus_in),
    .dma_rd_stb  (dma_rd_stb),
    .rx_byte     (rx_byte),
    .rx_valid    (rx_valid),
    .tx_byte     (tx_byte),
    .dma_wr_stb  (dma_wr_stb),
    .bus_out     (bus_out),
    .bus_oe_lo   (bus_oe_lo),
    .bus_oe_hi   (bus_oe_hi)
);

// File: tb/sim_dma_lane_steer.sv
`timescale 1ns/1ps
module sim_dma_lane_steer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic        dma_addr0 = 1'b0;
    logic [15:0] bus_in = '0;
    logic        dma_rd_stb = 1'b0;
    logic [7:0]  rx_byte;
    logic        rx_valid;
    logic [7:0]  tx_byte = '0;
    logic        dma_wr_stb = 1'b0;
    logic [15:0] bus_out;
    logic        bus_oe_lo;
    logic        bus_oe_hi;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    dma_lane_steer u0 (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data), .cfg_rd_data(cfg_rd_data),
        .dma_addr0(dma_addr0), .bus_in(bus_in), .dma_rd_stb(dma_rd_stb),
        .rx_byte(rx_byte), .rx_valid(rx_valid),
        .tx_byte(tx_byte), .dma_wr_stb(dma_wr_stb),
        .bus_out(bus_out), .bus_oe_lo(bus_oe_lo), .bus_oe_hi(bus_oe_hi)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wr_data = ~v;
    endtask

    // Expected lane per R3/R4/R5: high lane only when enabled and A0 equals polarity
    function automatic logic [7:0] exp_lane(input logic en, input logic pol,
                                            input logic a0, input logic [15:0] w);
        return (en && (a0 == pol)) ? w[15:8] : w[7:0];
    endfunction

    task automatic rd_xfer(input logic en, input logic pol, input logic a0,
                           input logic [15:0] w, input string req);
        logic [7:0] e;
        e = exp_lane(en, pol, a0, w);
        @(negedge clk);
        dma_addr0  = a0;
        bus_in     = w;
        dma_rd_stb = 1'b1;
        @(negedge clk);
        dma_rd_stb = 1'b0;
        bus_in     = ~w;
        dma_addr0  = ~a0;
        chk(req, {24'd0, rx_byte}, {24'd0, e});
        chk("R6 valid pulse", {31'd0, rx_valid}, 32'd1);
        @(negedge clk);
        chk("R6 valid drops", {31'd0, rx_valid}, 32'd0);
        chk("R6 hold", {24'd0, rx_byte}, {24'd0, e});
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] pats [6];
        pats[0] = 16'hA55A; pats[1] = 16'h3CC3; pats[2] = 16'hFF00;
        pats[3] = 16'h00FF; pats[4] = 16'h1234; pats[5] = 16'hDEAD;

        #3;
        chk("R1 cfg reset", {24'd0, cfg_rd_data}, 32'h00);
        chk("R1 valid reset", {31'd0, rx_valid}, 32'd0);
        chk("R1 byte reset", {24'd0, rx_byte}, 32'h00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 cfg after release", {24'd0, cfg_rd_data}, 32'h00);

        // R1: default is swap disabled, so odd address still takes low lane
        rd_xfer(1'b0, 1'b0, 1'b1, 16'hBEEF, "R1 default low lane");

        // R2: full sweep of configuration byte
        for (int v = 0; v < 256; v++) begin
            cfg_write(v[7:0]);
            chk("R2 readback", {24'd0, cfg_rd_data}, {24'd0, v[7:0] & 8'hC7});
        end

        // R3/R4/R5: all configs, both parities, several patterns; reserved bits set too
        for (int c = 0; c < 4; c++) begin
            logic en, pol;
            en  = c[1];
            pol = c[0];
            cfg_write({en, pol, 3'b111, 3'b010});
            for (int a = 0; a < 2; a++) begin
                for (int p = 0; p < 6; p++) begin
                    rd_xfer(en, pol, a[0], pats[p],
                            !en ? "R3 no swap" : (pol ? "R4 pol one" : "R5 pol zero"));
                end
                for (int b = 0; b < 8; b++) begin
                    rd_xfer(en, pol, a[0], {8'h01 << b, ~(8'h01 << b)},
                            !en ? "R3 walk" : (pol ? "R4 walk" : "R5 walk"));
                end
            end
        end

        // R6: back-to-back strobes, valid stays high, byte follows each transfer
        cfg_write(8'hC0);
        @(negedge clk);
        dma_rd_stb = 1'b1; dma_addr0 = 1'b0; bus_in = 16'h1122;
        @(negedge clk);
        chk("R6 b2b first", {24'd0, rx_byte}, 32'h22);
        chk("R6 b2b valid", {31'd0, rx_valid}, 32'd1);
        dma_addr0 = 1'b1; bus_in = 16'h3344;
        @(negedge clk);
        dma_rd_stb = 1'b0;
        chk("R6 b2b second", {24'd0, rx_byte}, 32'h33);
        chk("R6 b2b valid2", {31'd0, rx_valid}, 32'd1);
        @(negedge clk);
        chk("R6 b2b end", {31'd0, rx_valid}, 32'd0);

        // R7/R8: outgoing bytes under several configs, strobe on and off
        for (int c = 0; c < 4; c++) begin
            cfg_write({c[1], c[0], 6'b0});
            for (int t = 0; t < 256; t++) begin
                @(negedge clk);
                tx_byte    = t[7:0];
                dma_wr_stb = t[0] ^ c[0];
                #1;
                chk("R7 mirror", {16'd0, bus_out}, {16'd0, t[7:0], t[7:0]});
                chk("R8 oe lo", {31'd0, bus_oe_lo}, {31'd0, dma_wr_stb});
                chk("R8 oe hi", {31'd0, bus_oe_hi}, {31'd0, dma_wr_stb});
            end
        end
        @(negedge clk);
        dma_wr_stb = 1'b0;
        #1;
        chk("R8 idle off", {30'd0, bus_oe_hi, bus_oe_lo}, 32'd0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule